// File: doc/BRIEF.md
# Output-Port Cell Filter and Lossy Concentrator

This block is the receive front end of one output port in an output-queued cell switch built on broadcast buses. In each slot every one of the `NUM_BUS` input buses may carry one cell. Each cell has a valid flag, a destination port number and a tag. A per-bus address filter passes only the valid cells whose destination equals this port's number (`MY_PORT`).

The surviving cells are then concentrated onto `NUM_LANE` output lanes. They are placed in ascending bus order starting at lane 0, so the occupied lanes always form a contiguous group at the bottom. When more than `NUM_LANE` cells survive in a slot, the cells from the highest-numbered buses are discarded in that same slot. The number discarded is added to a saturating loss counter.

The lanes and the counter are registered, so the result for a slot appears one clock after that slot's inputs are sampled.

Top module: `ko_concentrator`

## Requirements
- R1: While reset is asserted, and right after it is released, every lane valid bit is 0, every lane tag is 0 and the loss count is 0.
- R2: A cell whose destination differs from `MY_PORT` never appears on any lane and never adds to the loss count.
- R3: The valid lanes are always packed: if lane k is valid, then every lane below k is valid too.
- R4: Surviving cells take lanes in ascending bus order. The lowest-numbered matching bus goes to lane 0, the next to lane 1, and so on, and each lane carries that bus's tag unchanged.
- R5: The number of valid lanes equals the smaller of the matching-cell count and `NUM_LANE`.
- R6: Lanes and loss count change only at the clock edge that samples the slot's inputs, giving exactly one cycle of latency.
- R7: Each slot adds max(matches − `NUM_LANE`, 0) to the loss count, and the dropped cells are those from the highest-numbered matching buses.
- R8: The loss count saturates at 2^`DROP_W` − 1 and stays there.
- R9: A bus with its valid bit at 0 is ignored, even if its destination equals `MY_PORT`.
- R10: An invalid lane drives an all-zero tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | NUM_BUS | Per-bus cell present flag |
| dest_i | input | NUM_BUS*DEST_W | Per-bus destination port, bus b at bits [b*DEST_W +: DEST_W] |
| tag_i | input | NUM_BUS*TAG_W | Per-bus cell tag, bus b at bits [b*TAG_W +: TAG_W] |
| lane_valid_o | output | NUM_LANE | Lane occupied flag, registered |
| lane_tag_o | output | NUM_LANE*TAG_W | Lane tag, lane k at bits [k*TAG_W +: TAG_W], registered |
| drop_cnt_o | output | DROP_W | Saturating count of discarded matching cells |

## Verification
Several properties are checked on every cycle: lane packing, the number of valid lanes against the previous slot's match count, the loss-count update including saturation, and zero tags on empty lanes. Some properties can only be shown by the bench's scenarios against its queue-style reference model: which bus's tag lands on which lane, that the highest-numbered buses are the ones dropped, and that mismatched or invalid buses with look-alike destinations are rejected. The same applies to the one-cycle latency, which the bench observes between the drive and the next edge.

// File: rtl/ko_pkg.sv
package ko_pkg;
  function automatic int unsigned cnt_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/ko_filter.sv
module ko_filter #(
  parameter int unsigned NUM_BUS = 8,
  parameter int unsigned DEST_W  = 3,
  parameter int unsigned MY_PORT = 5
) (
  input  logic [NUM_BUS-1:0]        valid_i,
  input  logic [NUM_BUS*DEST_W-1:0] dest_i,
  output logic [NUM_BUS-1:0]        hit_o
);
  for (genvar b = 0; b < NUM_BUS; b++) begin : g_flt
    assign hit_o[b] = valid_i[b] && (dest_i[b*DEST_W +: DEST_W] == DEST_W'(MY_PORT));
  end
endmodule

// File: rtl/ko_packer.sv
module ko_packer #(
  parameter int unsigned NUM_BUS  = 8,
  parameter int unsigned NUM_LANE = 4,
  parameter int unsigned TAG_W    = 8,
  localparam int unsigned CNT_W   = ko_pkg::cnt_width(NUM_BUS)
) (
  input  logic [NUM_BUS-1:0]        hit_i,
  input  logic [NUM_BUS*TAG_W-1:0]  tag_i,
  output logic [NUM_LANE-1:0]       lane_valid_o,
  output logic [NUM_LANE*TAG_W-1:0] lane_tag_o,
  output logic [CNT_W-1:0]          excess_o
);
  logic [CNT_W-1:0] rank;

  // rank = number of hits on lower buses; a hit goes to lane == rank
  always_comb begin
    rank         = '0;
    lane_valid_o = '0;
    lane_tag_o   = '0;
    for (int b = 0; b < NUM_BUS; b++) begin
      if (hit_i[b]) begin
        for (int k = 0; k < NUM_LANE; k++) begin
          if (rank == CNT_W'(k)) begin
            lane_valid_o[k]              = 1'b1;
            lane_tag_o[k*TAG_W +: TAG_W] = tag_i[b*TAG_W +: TAG_W];
          end
        end
        rank = rank + 1'b1;
      end
    end
    excess_o = (rank > CNT_W'(NUM_LANE)) ? rank - CNT_W'(NUM_LANE) : '0;
  end
endmodule

// File: rtl/ko_drop_cnt.sv
module ko_drop_cnt #(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned DROP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  excess_i,
  output logic [DROP_W-1:0] cnt_o
);
  logic [DROP_W:0] sum;

  assign sum = {1'b0, cnt_o} + (DROP_W+1)'(excess_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_o <= '0;
    else if (sum[DROP_W]) cnt_o <= '1;
    else                  cnt_o <= sum[DROP_W-1:0];
  end
endmodule

// File: rtl/ko_concentrator.sv
module ko_concentrator #(
  parameter int unsigned NUM_BUS  = 8,
  parameter int unsigned NUM_LANE = 4,
  parameter int unsigned DEST_W   = 3,
  parameter int unsigned TAG_W    = 8,
  parameter int unsigned DROP_W   = 16,
  parameter int unsigned MY_PORT  = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_BUS-1:0]        valid_i,
  input  logic [NUM_BUS*DEST_W-1:0] dest_i,
  input  logic [NUM_BUS*TAG_W-1:0]  tag_i,
  output logic [NUM_LANE-1:0]       lane_valid_o,
  output logic [NUM_LANE*TAG_W-1:0] lane_tag_o,
  output logic [DROP_W-1:0]         drop_cnt_o
);
  localparam int unsigned CNT_W = ko_pkg::cnt_width(NUM_BUS);

  logic [NUM_BUS-1:0]        hit;
  logic [NUM_LANE-1:0]       pk_valid;
  logic [NUM_LANE*TAG_W-1:0] pk_tag;
  logic [CNT_W-1:0]          excess;

  ko_filter #(.NUM_BUS(NUM_BUS), .DEST_W(DEST_W), .MY_PORT(MY_PORT)) u_filter (
    .valid_i(valid_i), .dest_i(dest_i), .hit_o(hit)
  );

  ko_packer #(.NUM_BUS(NUM_BUS), .NUM_LANE(NUM_LANE), .TAG_W(TAG_W)) u_packer (
    .hit_i(hit), .tag_i(tag_i), .lane_valid_o(pk_valid), .lane_tag_o(pk_tag), .excess_o(excess)
  );

  ko_drop_cnt #(.CNT_W(CNT_W), .DROP_W(DROP_W)) u_drop (
    .clk_i(clk_i), .rst_ni(rst_ni), .excess_i(excess), .cnt_o(drop_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_valid_o <= '0;
      lane_tag_o   <= '0;
    end else begin
      lane_valid_o <= pk_valid;
      lane_tag_o   <= pk_tag;
    end
  end
endmodule

// File: rtl/ko_concentrator_chk.sv
module ko_concentrator_chk #(
  parameter int unsigned NUM_BUS  = 8,
  parameter int unsigned NUM_LANE = 4,
  parameter int unsigned DEST_W   = 3,
  parameter int unsigned TAG_W    = 8,
  parameter int unsigned DROP_W   = 16,
  parameter int unsigned MY_PORT  = 5
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_BUS-1:0]        valid_i,
  input logic [NUM_BUS*DEST_W-1:0] dest_i,
  input logic [NUM_LANE-1:0]       lane_valid_o,
  input logic [NUM_LANE*TAG_W-1:0] lane_tag_o,
  input logic [DROP_W-1:0]         drop_cnt_o
);
  localparam logic [DROP_W-1:0] MAX_CNT = '1;

  int unsigned     n_match;
  int unsigned     n_lane_exp;
  logic [DROP_W:0] next_sum;
  logic [DROP_W-1:0] next_cnt;

  always_comb begin
    n_match = 0;
    for (int b = 0; b < NUM_BUS; b++)
      if (valid_i[b] && dest_i[b*DEST_W +: DEST_W] == DEST_W'(MY_PORT)) n_match++;
    n_lane_exp = (n_match < NUM_LANE) ? n_match : NUM_LANE;
    next_sum   = {1'b0, drop_cnt_o} + (DROP_W+1)'(n_match - n_lane_exp);
    next_cnt   = next_sum[DROP_W] ? MAX_CNT : next_sum[DROP_W-1:0];
  end

  a_r3_packed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lane_valid_o + 1'b1) & lane_valid_o) == '0);

  a_r5_lane_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $countones(lane_valid_o) == $past(n_lane_exp));

  a_r7_drop_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> drop_cnt_o == $past(next_cnt));

  a_r8_sat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_cnt_o == MAX_CNT |=> drop_cnt_o == MAX_CNT);

  for (genvar k = 0; k < NUM_LANE; k++) begin : g_r10
    a_r10_idle_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lane_valid_o[k] |-> lane_tag_o[k*TAG_W +: TAG_W] == '0);
  end
endmodule

bind ko_concentrator ko_concentrator_chk #(
  .NUM_BUS(NUM_BUS), .NUM_LANE(NUM_LANE), .DEST_W(DEST_W),
  .TAG_W(TAG_W), .DROP_W(DROP_W), .MY_PORT(MY_PORT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .dest_i(dest_i),
  .lane_valid_o(lane_valid_o), .lane_tag_o(lane_tag_o), .drop_cnt_o(drop_cnt_o)
);

// File: tb/ko_concentrator_bench.sv
module ko_concentrator_bench;
  localparam int NB = 8, NL = 4, DW = 3, TW = 8, CW = 6, PORT = 5;
  localparam int MAXC = (1 << CW) - 1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [NB-1:0]    valid_i = '0;
  logic [NB*DW-1:0] dest_i  = '0;
  logic [NB*TW-1:0] tag_i   = '0;
  logic [NL-1:0]    lane_valid_o;
  logic [NL*TW-1:0] lane_tag_o;
  logic [CW-1:0]    drop_cnt_o;

  int n_chk = 0, n_err = 0;
  int exp_cnt = 0;
  logic [NL-1:0]    exp_v = '0;
  logic [NL*TW-1:0] exp_t = '0;

  always #10 clk_i = ~clk_i;

  ko_concentrator #(.NUM_BUS(NB), .NUM_LANE(NL), .DEST_W(DW), .TAG_W(TW),
                    .DROP_W(CW), .MY_PORT(PORT)) u_ko_concentrator (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .dest_i(dest_i), .tag_i(tag_i),
    .lane_valid_o(lane_valid_o), .lane_tag_o(lane_tag_o), .drop_cnt_o(drop_cnt_o)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    for (int k = 0; k < NL; k++) begin
      check(lane_valid_o[k] == exp_v[k], {"R3/R5/", req}, $sformatf("lane%0d valid", k),
            lane_valid_o[k], exp_v[k]);
      check(lane_tag_o[k*TW +: TW] == exp_t[k*TW +: TW],
            exp_v[k] ? {"R4/", req} : {"R10/", req}, $sformatf("lane%0d tag", k),
            lane_tag_o[k*TW +: TW], exp_t[k*TW +: TW]);
    end
    check(drop_cnt_o == CW'(exp_cnt), {"R7/", req}, "drop count", drop_cnt_o, exp_cnt);
  endtask

  // drive at negedge, verify R6 before the edge, then compare after it
  task automatic step(input logic [NB-1:0] v, input logic [NB*DW-1:0] d,
                      input logic [NB*TW-1:0] t, input string req);
    int n;
    valid_i = v; dest_i = d; tag_i = t;
    #1;
    check(lane_valid_o == exp_v && drop_cnt_o == CW'(exp_cnt), {"R6/", req},
          "output moved before edge", lane_valid_o, exp_v);
    n = 0; exp_v = '0; exp_t = '0;
    for (int b = 0; b < NB; b++) begin
      if (v[b] && d[b*DW +: DW] == DW'(PORT)) begin
        if (n < NL) begin
          exp_v[n] = 1'b1;
          exp_t[n*TW +: TW] = t[b*TW +: TW];
        end
        n++;
      end
    end
    if (n > NL) exp_cnt = exp_cnt + n - NL;
    if (exp_cnt > MAXC) exp_cnt = MAXC;
    @(posedge clk_i); @(negedge clk_i);
    compare(req);
  endtask

  function automatic logic [NB*DW-1:0] all_dest(input int p);
    logic [NB*DW-1:0] r;
    for (int b = 0; b < NB; b++) r[b*DW +: DW] = DW'(p);
    return r;
  endfunction

  function automatic logic [NB*TW-1:0] seq_tags(input int base);
    logic [NB*TW-1:0] r;
    for (int b = 0; b < NB; b++) r[b*TW +: TW] = TW'(base + b);
    return r;
  endfunction

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog act=0 exp=1");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [NB*DW-1:0] d;
    repeat (3) @(negedge clk_i);
    compare("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1 after release");

    step('0, all_dest(PORT), seq_tags(8'h10), "R9 no valid");
    step('1, all_dest(2), seq_tags(8'h20), "R2 wrong port");
    step(8'b0000_0001, all_dest(PORT), seq_tags(8'h30), "R4 single");
    step(8'b1000_0000, all_dest(PORT), seq_tags(8'h40), "R3 top bus only");
    step(8'b1010_0100, all_dest(PORT), seq_tags(8'h50), "R4 sparse");
    step(8'b0000_1111, all_dest(PORT), seq_tags(8'h60), "R5 exactly four");
    step(8'b0001_1111, all_dest(PORT), seq_tags(8'h70), "R7 five");
    step('1, all_dest(PORT), seq_tags(8'h80), "R7 all eight");
    d = all_dest(PORT);
    d[0 +: DW] = DW'(4); d[3*DW +: DW] = DW'(6); d[6*DW +: DW] = DW'(1);
    step('1, d, seq_tags(8'h90), "R2 mixed");
    step(8'b1111_0110, all_dest(PORT), seq_tags(8'hA0), "R9 partial valid");

    for (int i = 0; i < 60; i++) begin
      logic [NB*DW-1:0] rd;
      logic [NB*TW-1:0] rt;
      for (int b = 0; b < NB; b++) begin
        rd[b*DW +: DW] = ($urandom_range(0, 1) == 0) ? DW'(PORT) : DW'($urandom_range(0, 7));
        rt[b*TW +: TW] = TW'($urandom_range(1, 255));
      end
      step(NB'($urandom), rd, rt, "R4 random");
    end

    for (int i = 0; i < 20; i++) step('1, all_dest(PORT), seq_tags(i), "R8 fill");
    check(drop_cnt_o == CW'(MAXC), "R8", "saturated", drop_cnt_o, MAXC);
    step('1, all_dest(PORT), seq_tags(8'hC0), "R8 hold");
    step('0, all_dest(0), '0, "R10 idle");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule